// File: doc/BRIEF.md
# Dual-Clock Mailbox Register with Handshake Flag

This block moves a single word from a writer clock domain to a reader clock domain outside the path of a companion data FIFO. The writer deposits a word by selecting the mailbox on a write cycle. An active-low flag then shows that a word is pending, and any further deposit is refused until the reader has taken the word. The reader takes the word by selecting the mailbox on a read cycle. That returns the flag to its idle (high) level in the reader domain, and the writer sees the same change a few writer clocks later.

The flag is kept as a pair of toggle bits. One bit is flipped by the writer and one by the reader, and each is carried into the other domain through a chain of synchronising flops. The word itself is never synchronised bit by bit. It stays frozen for as long as the flag shows it pending, so the reader always samples a settled value. On the reader side, the mailbox select also steers the shared output bus: it shows either the mailbox word or the word from the FIFO output register. One asynchronous reset input, shared with the companion FIFO, clears both domains. Each domain releases that reset in step with its own clock.

Top module: `xdom_mailbox`

## Requirements
- R1: A rising `wclk` edge with `w_sel`=1, `w_en`=1 and `w_flag_n`=1 loads `w_data` into the mailbox, and `w_flag_n` reads 0 directly after that edge.
- R2: While `w_flag_n`=0, a writer cycle with `w_sel`=1 and `w_en`=1 leaves the stored word unchanged.
- R3: A writer cycle with `w_sel`=0 or `w_en`=0 neither changes the stored word nor the flags.
- R4: After an accepted write, `r_flag_n` falls to 0 within SYNC_STAGES+2 rising `rclk` edges (4 with defaults).
- R5: A rising `rclk` edge with `r_sel`=1, `r_en`=1 and `r_flag_n`=0 returns `r_flag_n` to 1 directly after that edge, and `w_flag_n` returns to 1 within SYNC_STAGES+2 rising `wclk` edges.
- R6: A reader cycle with `r_en`=1 but `r_sel`=0 does not consume the word: `r_flag_n` stays 0.
- R7: `r_data` equals the mailbox word while `r_sel`=1 and equals `fifo_word` while `r_sel`=0, combinationally.
- R8: `rst_n`=0 forces `w_flag_n` and `r_flag_n` to 1 at once and clears the mailbox word to zero; after release no word is pending.
- R9: Under continuous write attempts and continuous reads, every accepted word reaches the reader exactly once and in write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset shared with the companion FIFO |
| wclk | input | 1 | Writer domain clock |
| w_sel | input | 1 | Writer mailbox select |
| w_en | input | 1 | Writer write strobe |
| w_data | input | WIDTH | Word offered to the mailbox |
| w_flag_n | output | 1 | Flag in writer domain, 0 = word pending |
| rclk | input | 1 | Reader domain clock |
| r_sel | input | 1 | Reader mailbox select, also steers `r_data` |
| r_en | input | 1 | Reader read strobe |
| fifo_word | input | WIDTH | Word from the FIFO output register |
| r_data | output | WIDTH | Reader output bus |
| r_flag_n | output | 1 | Flag in reader domain, 0 = word pending |

## Verification
The bench attacks the overwrite lockout by offering a second word while the first is still pending. A design that forgot the lockout would deliver the second word and lose the first, and the scoreboard would flag it. Reads without the mailbox select, and writes without the select or the strobe, show whether a design wrongly decodes the strobe alone: the flag would drop or a stray word would appear. A long run of back-to-back attempts from both sides checks the toggle round trip, since a design that cleared its full state too early would either duplicate or drop words. A reset applied while a word is pending must raise both flags at once, not after a synchroniser delay.

// File: rtl/xmb_pkg.sv
package xmb_pkg;
   typedef enum logic {
      MBX_FULL  = 1'b0,
      MBX_EMPTY = 1'b1
   } mbx_flag_e;

   function automatic mbx_flag_e flag_of(input logic pending);
      return pending ? MBX_FULL : MBX_EMPTY;
   endfunction
endpackage

// File: rtl/xmb_bit_sync.sv
module xmb_bit_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("xmb_bit_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stg_q;

   if (STAGES == 2) begin : g_two
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg_q <= '0;
         else        stg_q <= {stg_q[0], d};
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg_q <= '0;
         else        stg_q <= {stg_q[STAGES-2:0], d};
      end
   end

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/xmb_wr_side.sv
module xmb_wr_side
   import xmb_pkg::*;
#(
   parameter int WIDTH  = 36,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_i,
   input  logic             en_i,
   input  logic [WIDTH-1:0] din_i,
   input  logic             clr_tgl_i,
   output logic             set_tgl_o,
   output logic [WIDTH-1:0] word_o,
   output logic             flag_n_o
);
   logic             clr_seen;
   logic             set_tgl_q;
   logic [WIDTH-1:0] word_q;
   logic             pending;
   logic             wr_try;
   logic             wr_ok;

   xmb_bit_sync #(.STAGES(STAGES)) u_clr_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (clr_tgl_i),
      .q     (clr_seen)
   );

   assign pending = set_tgl_q ^ clr_seen;
   assign wr_try  = sel_i & en_i;
   assign wr_ok   = wr_try & ~pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         set_tgl_q <= 1'b0;
         word_q    <= '0;
      end else if (wr_ok) begin
         set_tgl_q <= ~set_tgl_q;
         word_q    <= din_i;
      end
   end

   assign set_tgl_o = set_tgl_q;
   assign word_o    = word_q;
   assign flag_n_o  = flag_of(pending);

   AST_WR_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |=> !flag_n_o); // R1

   AST_WR_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_n_o |=> $stable(word_o)); // R2

   AST_WR_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_try |=> $stable(word_o) && $stable(set_tgl_o)); // R3
endmodule

// File: rtl/xmb_rd_side.sv
module xmb_rd_side
   import xmb_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_i,
   input  logic en_i,
   input  logic set_tgl_i,
   output logic clr_tgl_o,
   output logic flag_n_o
);
   logic set_seen;
   logic clr_tgl_q;
   logic pending;
   logic consume;

   xmb_bit_sync #(.STAGES(STAGES)) u_set_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (set_tgl_i),
      .q     (set_seen)
   );

   assign pending = set_seen ^ clr_tgl_q;
   assign consume = sel_i & en_i & pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       clr_tgl_q <= 1'b0;
      else if (consume) clr_tgl_q <= ~clr_tgl_q;
   end

   assign clr_tgl_o = clr_tgl_q;
   assign flag_n_o  = flag_of(pending);

   AST_RD_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      consume |=> flag_n_o); // R5

   AST_RD_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_n_o && !consume) |=> !flag_n_o); // R6
endmodule

// File: rtl/xdom_mailbox.sv
module xdom_mailbox #(
   parameter int WIDTH       = 36,
   parameter int SYNC_STAGES = 2
) (
   input  logic             rst_n,
   input  logic             wclk,
   input  logic             w_sel,
   input  logic             w_en,
   input  logic [WIDTH-1:0] w_data,
   output logic             w_flag_n,
   input  logic             rclk,
   input  logic             r_sel,
   input  logic             r_en,
   input  logic [WIDTH-1:0] fifo_word,
   output logic [WIDTH-1:0] r_data,
   output logic             r_flag_n
);
   if (WIDTH < 1) begin : g_bad_width
      $error("xdom_mailbox: WIDTH must be positive");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("xdom_mailbox: SYNC_STAGES must be at least 2");
   end

   logic             w_rst_n;
   logic             r_rst_n;
   logic             set_tgl;
   logic             clr_tgl;
   logic [WIDTH-1:0] mbox_word;

   xmb_bit_sync #(.STAGES(SYNC_STAGES)) u_wrst (
      .clk   (wclk),
      .rst_n (rst_n),
      .d     (1'b1),
      .q     (w_rst_n)
   );

   xmb_bit_sync #(.STAGES(SYNC_STAGES)) u_rrst (
      .clk   (rclk),
      .rst_n (rst_n),
      .d     (1'b1),
      .q     (r_rst_n)
   );

   xmb_wr_side #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_wr (
      .clk       (wclk),
      .rst_n     (w_rst_n),
      .sel_i     (w_sel),
      .en_i      (w_en),
      .din_i     (w_data),
      .clr_tgl_i (clr_tgl),
      .set_tgl_o (set_tgl),
      .word_o    (mbox_word),
      .flag_n_o  (w_flag_n)
   );

   xmb_rd_side #(.STAGES(SYNC_STAGES)) u_rd (
      .clk       (rclk),
      .rst_n     (r_rst_n),
      .sel_i     (r_sel),
      .en_i      (r_en),
      .set_tgl_i (set_tgl),
      .clr_tgl_o (clr_tgl),
      .flag_n_o  (r_flag_n)
   );

   assign r_data = r_sel ? mbox_word : fifo_word;

   AST_RD_WORD_SETTLED: assert property (@(posedge rclk) disable iff (!r_rst_n)
      (!r_flag_n && $past(!r_flag_n)) |-> $stable(mbox_word)); // R2
endmodule

// File: tb/xdom_mailbox_tb.sv
module xdom_mailbox_tb;
   localparam int W = 36;

   logic         rst_n = 1'b0;
   logic         wclk  = 1'b0;
   logic         rclk  = 1'b0;
   logic         w_sel = 1'b0, w_en = 1'b0;
   logic [W-1:0] w_data = '0;
   logic         r_sel = 1'b0, r_en = 1'b0;
   logic [W-1:0] fifo_word = '0;
   logic         w_flag_n, r_flag_n;
   logic [W-1:0] r_data;

   int n_chk = 0;
   int n_err = 0;
   int delivered = 0;
   logic [W-1:0] exp_q[$];

   always #5 wclk = ~wclk;
   always #7 rclk = ~rclk;

   xdom_mailbox #(.WIDTH(W), .SYNC_STAGES(2)) u_dut (
      .rst_n(rst_n), .wclk(wclk), .w_sel(w_sel), .w_en(w_en), .w_data(w_data),
      .w_flag_n(w_flag_n), .rclk(rclk), .r_sel(r_sel), .r_en(r_en),
      .fifo_word(fifo_word), .r_data(r_data), .r_flag_n(r_flag_n)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   // monitor: a read that will be accepted at the next rclk edge pops the scoreboard
   always @(negedge rclk) begin
      if (rst_n && r_sel && r_en && r_flag_n === 1'b0) begin
         if (exp_q.size() == 0) begin
            chk("R9 unexpected word", r_data, '1 ^ r_data);
         end else begin
            chk("R9 word order", r_data, exp_q.pop_front());
         end
         delivered++;
      end
   end

   // driver: one writer cycle; pushes the word when the flag allows acceptance
   task automatic wr_cycle(input logic sel, input logic en, input logic [W-1:0] d);
      @(posedge wclk) #1;
      w_sel = sel; w_en = en; w_data = d;
      if (sel && en && w_flag_n) exp_q.push_back(d);
      @(posedge wclk) #1;
      w_sel = 1'b0; w_en = 1'b0;
   endtask

   task automatic wait_rflag(input logic val, output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(posedge rclk) #1;
         if (r_flag_n === val) begin ok = 1'b1; break; end
      end
   endtask

   task automatic wait_wflag(input logic val, output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(posedge wclk) #1;
         if (w_flag_n === val) begin ok = 1'b1; break; end
      end
   endtask

   task automatic settle;
      repeat (5) @(posedge wclk);
      repeat (5) @(posedge rclk);
      #1;
   endtask

   initial begin
      #1_500_000;
      n_err++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      bit ok;
      #23;
      // R8: flags high during reset
      chk("R8 w_flag_n in reset", {35'd0, w_flag_n}, 36'd1);
      chk("R8 r_flag_n in reset", {35'd0, r_flag_n}, 36'd1);
      rst_n = 1'b1;
      settle();

      // R7: mux shows FIFO word while r_sel is low
      fifo_word = 36'h9_1234_5678; #1;
      chk("R7 fifo path", r_data, 36'h9_1234_5678);
      fifo_word = 36'h0_0F0F_00F0; #1;
      chk("R7 fifo path 2", r_data, 36'h0_0F0F_00F0);
      r_sel = 1'b1; #1;
      chk("R8 mailbox word zero after reset", r_data, 36'd0);
      r_sel = 1'b0;

      // R3: writes lacking select or strobe are ignored
      wr_cycle(1'b0, 1'b1, 36'hA_AAAA_AAAA);
      wr_cycle(1'b1, 1'b0, 36'h5_5555_5555);
      chk("R3 w_flag_n stays high", {35'd0, w_flag_n}, 36'd1);
      settle();
      chk("R3 r_flag_n stays high", {35'd0, r_flag_n}, 36'd1);
      r_sel = 1'b1; #1;
      chk("R3 word unchanged", r_data, 36'd0);
      r_sel = 1'b0;

      // R1: accepted write
      wr_cycle(1'b1, 1'b1, 36'hC_0DE0_0001);
      chk("R1 w_flag_n low after write", {35'd0, w_flag_n}, 36'd0);
      wait_rflag(1'b0, ok);
      chk("R4 r_flag_n falls", {35'd0, ok}, 36'd1);

      // R2: second write while pending is ignored
      wr_cycle(1'b1, 1'b1, 36'hF_FFFF_0002);
      settle();
      r_sel = 1'b1; #1;
      chk("R2 word kept", r_data, 36'hC_0DE0_0001);
      r_sel = 1'b0;

      // R6: read without select does not consume
      @(posedge rclk) #1; r_en = 1'b1;
      @(posedge rclk) #1;
      @(posedge rclk) #1; r_en = 1'b0;
      chk("R6 r_flag_n still low", {35'd0, r_flag_n}, 36'd0);

      // R5: proper read clears the flag
      @(posedge rclk) #1; r_sel = 1'b1; r_en = 1'b1;
      @(posedge rclk) #1; r_en = 1'b0; r_sel = 1'b0;
      chk("R5 r_flag_n high after read", {35'd0, r_flag_n}, 36'd1);
      wait_wflag(1'b1, ok);
      chk("R5 w_flag_n returns high", {35'd0, ok}, 36'd1);
      chk("R9 first word delivered", 36'(delivered), 36'd1);

      // R9: continuous traffic from both sides
      delivered = 0;
      fork
         begin
            for (int i = 0; exp_q.size() + delivered < 12 && i < 2000; i++) begin
               @(posedge wclk) #1;
               w_sel = 1'b1; w_en = 1'b1; w_data = 36'h3_0000_0000 + 36'(i);
               if (w_flag_n) exp_q.push_back(w_data);
            end
            @(posedge wclk) #1;
            w_sel = 1'b0; w_en = 1'b0;
         end
         begin
            @(posedge rclk) #1; r_sel = 1'b1; r_en = 1'b1;
            for (int k = 0; delivered < 12 && k < 4000; k++) @(posedge rclk);
            #1; r_en = 1'b0; r_sel = 1'b0;
         end
      join
      chk("R9 words delivered", 36'(delivered), 36'd12);
      chk("R9 nothing left", 36'(exp_q.size()), 36'd0);
      settle();

      // R8: reset while a word is pending
      wr_cycle(1'b1, 1'b1, 36'h7_7777_7777);
      wait_rflag(1'b0, ok);
      chk("R4 r_flag_n falls again", {35'd0, ok}, 36'd1);
      #2 rst_n = 1'b0; #1;
      exp_q.delete();
      chk("R8 w_flag_n forced high", {35'd0, w_flag_n}, 36'd1);
      chk("R8 r_flag_n forced high", {35'd0, r_flag_n}, 36'd1);
      #20 rst_n = 1'b1;
      settle();
      chk("R8 no word pending after reset", {35'd0, r_flag_n}, 36'd1);

      finish_run();
   end
endmodule